// File: doc/BRIEF.md
# MDIO Management Master

This block lets a processor reach the management registers of an Ethernet PHY over the two-wire MDIO interface (Clause 22 frames). Software sees four 32-bit registers on a simple synchronous bus. One holds the target (PHY address, register number and a read/write flag). One holds the outgoing 16-bit value. One returns the 16-bit value captured by the last read. The last is a control word with an enable flag and a busy flag.

A transaction starts when software writes the control word with both the busy flag and the enable flag set. The block then produces MDC from the system clock and shifts out one 64-bit frame, most significant bit first. The frame is made of 32 preamble ones, start pattern 01, opcode (10 read, 01 write), PHY address, register number, turnaround and 16 data bits. During a read it releases the line for the turnaround and data and samples the PHY on rising MDC. The busy flag falls when the frame is over. For a read, the captured value is then ready.

Top module: `mdio_mgmt_master`

## Requirements
- R1: After reset, every readable register returns 0, MDC is low and the MDIO output enable is low.
- R2: Control bit 3 (enable) reads back exactly as last written. A control write with bit 0 set but bit 3 clear starts nothing: busy stays 0 and MDC stays low.
- R3: A control write with bit 0 and bit 3 both set, while idle, makes control bit 0 read 1. It returns to 0 after exactly 64 MDC periods (128*DIV_HALF system cycles after the write edge).
- R4: A write frame carries 32 ones, 01, opcode 01, PHY address (address register bits [9:5]), register number (bits [4:0]), turnaround 10 and write-data bits [15:0], MSB first, with MDIO driven for all 64 bits. Address register bit 10 = 0 selects a write.
- R5: A read frame (address bit 10 = 1) carries opcode 10. MDIO is driven for the first 46 bits and released (output enable low) for the 2 turnaround and 16 data bits.
- R6: During a read, the value on MDIO at the 16 rising MDC edges of the data phase is assembled MSB first. It appears in read-data bits [15:0] once busy clears. Bits [31:16] read 0.
- R7: MDC is low whenever the block is idle. While busy it has a period of 2*DIV_HALF system cycles (DIV_HALF=10 gives 2.5 MHz from 50 MHz).
- R8: The MDIO output and output enable change only together with a falling edge of MDC. They are steady while MDC is high, which gives half an MDC period of setup and hold around each rising edge.
- R9: While busy, a write of 1 to control bit 0 is ignored and a write of 0 to it has no effect. The running frame finishes unchanged and on time.
- R10: Register offsets are 0x7E4 (address), 0x7E8 (write data), 0x7EC (read data) and 0x7F0 (control). The address register reads back bits [10:0] and the write-data register bits [15:0]; all other bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Byte offset of the register accessed |
| bus_we | input | 1 | Register write strobe |
| bus_re | input | 1 | Register read strobe; data is valid the following cycle |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Registered read data |
| mdc | output | 1 | Management clock to the PHY |
| mdio_i | input | 1 | Sampled level of the MDIO line |
| mdio_o | output | 1 | Value driven onto MDIO when enabled |
| mdio_oe | output | 1 | MDIO output enable; low releases the line |

## Verification
Frames are exercised with writes and reads to address and data patterns that mix all-ones, all-zeros and alternating bits. A field that is swapped, shifted or bit-reversed therefore shows up in the captured frame, and so does a wrong opcode or turnaround. The PHY model answers reads with asymmetric values, which exposes sampling on the wrong edge or in the wrong phase and byte-order errors in the read-data register. Directed cases then separate enable gating, busy duration and MDC period, and show that start and clear writes have no effect on a frame in flight.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int PHY_W     = 5;
  localparam int REG_W     = 5;
  localparam int VAL_W     = 16;
  localparam int PRE_LEN   = 32;
  localparam int FRAME_LEN = PRE_LEN + 2 + 2 + PHY_W + REG_W + 2 + VAL_W;
  localparam int RELEASE_AT = FRAME_LEN - VAL_W - 2;  // first bit not driven on reads
  localparam int DATA_AT    = FRAME_LEN - VAL_W;      // first data bit

  localparam logic [11:0] OFS_TARGET = 12'h7E4;
  localparam logic [11:0] OFS_WVAL   = 12'h7E8;
  localparam logic [11:0] OFS_RVAL   = 12'h7EC;
  localparam logic [11:0] OFS_CTRL   = 12'h7F0;

  localparam int CTRL_BUSY = 0;
  localparam int CTRL_EN   = 3;
  localparam int TGT_RD    = PHY_W + REG_W;
  localparam int TGT_W     = TGT_RD + 1;
endpackage

// File: rtl/mdio_clkdiv.sv
module mdio_clkdiv #(
  parameter int DIV_HALF = 10
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic mdc,
  output logic rise_now,
  output logic fall_now
);
  localparam int CNT_W = (DIV_HALF > 1) ? $clog2(DIV_HALF) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(DIV_HALF - 1);

  logic [CNT_W-1:0] cnt;
  logic             toggle;

  assign toggle   = run && (cnt == CNT_LAST);
  assign rise_now = toggle && !mdc;
  assign fall_now = toggle && mdc;

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt <= '0;
      mdc <= 1'b0;
    end else if (toggle) begin
      cnt <= '0;
      mdc <= !mdc;
    end else begin
      cnt <= cnt + CNT_W'(1);
    end
  end

  AST_MDC_HOLD_HALF: assert property (@(posedge clk) disable iff (rst)
    (run && $past(run) && cnt != CNT_LAST) |=> $stable(mdc)); // R7
endmodule

// File: rtl/mdio_frame_engine.sv
module mdio_frame_engine
  import mdio_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             is_read,
  input  logic [PHY_W-1:0] phy,
  input  logic [REG_W-1:0] regno,
  input  logic [VAL_W-1:0] wval,
  input  logic             rise_now,
  input  logic             fall_now,
  input  logic             mdio_i,
  output logic             busy,
  output logic             mdio_o,
  output logic             mdio_oe,
  output logic [VAL_W-1:0] rval
);
  localparam int IDX_W = $clog2(FRAME_LEN);
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(FRAME_LEN - 1);
  localparam logic [IDX_W-1:0] IDX_REL  = IDX_W'(RELEASE_AT);
  localparam logic [IDX_W-1:0] IDX_DATA = IDX_W'(DATA_AT);

  logic [FRAME_LEN-1:0] frame, shreg;
  logic [IDX_W-1:0]     idx, idx_nx;
  logic [VAL_W-1:0]     rd_sh;
  logic                 rd_mode;

  assign frame = {{PRE_LEN{1'b1}}, 2'b01, (is_read ? 2'b10 : 2'b01), phy, regno,
                  (is_read ? 2'b11 : 2'b10), (is_read ? {VAL_W{1'b1}} : wval)};
  assign idx_nx = idx + IDX_W'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0; mdio_o <= 1'b0; mdio_oe <= 1'b0; rd_mode <= 1'b0;
      idx <= '0; shreg <= '0; rd_sh <= '0; rval <= '0;
    end else if (start && !busy) begin
      busy    <= 1'b1;
      idx     <= '0;
      shreg   <= frame;
      mdio_o  <= frame[FRAME_LEN-1];
      mdio_oe <= 1'b1;
      rd_mode <= is_read;
    end else if (busy) begin
      if (rise_now && rd_mode && idx >= IDX_DATA)
        rd_sh <= {rd_sh[VAL_W-2:0], mdio_i};
      if (fall_now) begin
        if (idx == IDX_LAST) begin
          busy    <= 1'b0;
          mdio_o  <= 1'b0;
          mdio_oe <= 1'b0;
          if (rd_mode) rval <= rd_sh;
        end else begin
          idx     <= idx_nx;
          shreg   <= {shreg[FRAME_LEN-2:0], 1'b0};
          mdio_o  <= shreg[FRAME_LEN-2];
          mdio_oe <= !(rd_mode && idx_nx >= IDX_REL);
        end
      end
    end
  end

  AST_HOLD_UNTIL_FALL: assert property (@(posedge clk) disable iff (rst)
    (busy && !fall_now) |=> ($stable(mdio_o) && $stable(mdio_oe))); // R8
  AST_READ_RELEASED: assert property (@(posedge clk) disable iff (rst)
    (busy && rd_mode && idx >= IDX_REL) |-> !mdio_oe); // R5
  AST_WRITE_DRIVEN: assert property (@(posedge clk) disable iff (rst)
    (busy && !rd_mode) |-> mdio_oe); // R4
  AST_NO_RESTART: assert property (@(posedge clk) disable iff (rst)
    (busy && start && !fall_now) |=> (busy && idx == $past(idx))); // R9
endmodule

// File: rtl/mdio_mgmt_master.sv
module mdio_mgmt_master
  import mdio_pkg::*;
#(
  parameter int ADDR_W   = 12,
  parameter int DATA_W   = 32,
  parameter int DIV_HALF = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic              bus_re,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              mdc,
  input  logic              mdio_i,
  output logic              mdio_o,
  output logic              mdio_oe
);
  localparam logic [ADDR_W-1:0] A_TGT  = ADDR_W'(OFS_TARGET);
  localparam logic [ADDR_W-1:0] A_WVAL = ADDR_W'(OFS_WVAL);
  localparam logic [ADDR_W-1:0] A_RVAL = ADDR_W'(OFS_RVAL);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(OFS_CTRL);

  logic [TGT_W-1:0] tgt_q;
  logic [VAL_W-1:0] wval_q, rval;
  logic             en_q, busy, start, ctrl_wr, rise_now, fall_now;

  assign ctrl_wr = bus_we && (bus_addr == A_CTRL);
  assign start   = ctrl_wr && bus_wdata[CTRL_BUSY] && bus_wdata[CTRL_EN];

  always_ff @(posedge clk) begin
    if (rst) begin
      tgt_q <= '0; wval_q <= '0; en_q <= 1'b0;
    end else if (bus_we) begin
      if (bus_addr == A_TGT)  tgt_q  <= bus_wdata[TGT_W-1:0];
      if (bus_addr == A_WVAL) wval_q <= bus_wdata[VAL_W-1:0];
      if (ctrl_wr)            en_q   <= bus_wdata[CTRL_EN];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else if (bus_re) begin
      case (bus_addr)
        A_TGT:   bus_rdata <= DATA_W'(tgt_q);
        A_WVAL:  bus_rdata <= DATA_W'(wval_q);
        A_RVAL:  bus_rdata <= DATA_W'(rval);
        A_CTRL:  bus_rdata <= DATA_W'({en_q, 2'b00, busy});
        default: bus_rdata <= '0;
      endcase
    end
  end

  mdio_clkdiv #(.DIV_HALF(DIV_HALF)) i_div (
    .clk(clk), .rst(rst), .run(busy),
    .mdc(mdc), .rise_now(rise_now), .fall_now(fall_now)
  );

  mdio_frame_engine i_eng (
    .clk(clk), .rst(rst), .start(start),
    .is_read(tgt_q[TGT_RD]), .phy(tgt_q[REG_W +: PHY_W]), .regno(tgt_q[REG_W-1:0]),
    .wval(wval_q), .rise_now(rise_now), .fall_now(fall_now), .mdio_i(mdio_i),
    .busy(busy), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .rval(rval)
  );

  AST_IDLE_MDC_LOW: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !mdc); // R7
  AST_START_SETS_BUSY: assert property (@(posedge clk) disable iff (rst)
    (start && !busy) |=> busy); // R3
  AST_ENABLE_GATES: assert property (@(posedge clk) disable iff (rst)
    (ctrl_wr && !bus_wdata[CTRL_EN] && !busy) |=> !busy); // R2
endmodule

// File: tb/test_mdio_mgmt_master.sv
module test_mdio_mgmt_master;
  localparam int DH = 10;
  localparam int TXN_CYC = 128 * DH;

  logic clk = 1'b0, rst = 1'b1;
  logic [11:0] bus_addr = '0;
  logic bus_we = 1'b0, bus_re = 1'b0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic mdc, mdio_i, mdio_o, mdio_oe;

  int n_chk = 0, n_bad = 0;
  always #10 clk = !clk;

  mdio_mgmt_master #(.DIV_HALF(DH)) i_mdio_mgmt_master (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we), .bus_re(bus_re),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .mdc(mdc), .mdio_i(mdio_i),
    .mdio_o(mdio_o), .mdio_oe(mdio_oe)
  );

  // PHY model: records each rising MDC, answers reads in the data phase
  int pos = 0;
  logic [63:0] cap, capoe;
  logic [15:0] resp = '0;
  realtime t_rise_prev = 0, t_rise_last = 0;
  always @(posedge mdc) begin
    if (pos < 64) begin
      cap[63-pos]   = mdio_o;
      capoe[63-pos] = mdio_oe;
    end
    pos++;
    t_rise_prev = t_rise_last;
    t_rise_last = $realtime;
  end
  always_comb mdio_i = (pos >= 48 && pos < 64) ? resp[63-pos] : 1'b1;

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk); bus_we = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_re = 1'b1;
    @(negedge clk); bus_re = 1'b0; d = bus_rdata;
  endtask

  // start a transaction; returns time of the clock edge that took the start
  task automatic kick(output realtime t0);
    pos = 0;
    @(negedge clk); bus_addr = 12'h7F0; bus_wdata = 32'h9; bus_we = 1'b1;
    t0 = $realtime + 10;
    @(negedge clk); bus_we = 1'b0;
  endtask

  // poll until busy clears; returns edge time where 0 was first sampled
  task automatic wait_idle(output realtime t1);
    logic [31:0] d;
    t1 = 0;
    for (int k = 0; k < 4000; k++) begin
      rd(12'h7F0, d);
      if (d[0] == 1'b0) begin t1 = $realtime - 10; break; end
    end
  endtask

  function automatic logic [63:0] exp_frame(logic r, logic [4:0] p, logic [4:0] g, logic [15:0] w);
    return {32'hFFFF_FFFF, 2'b01, (r ? 2'b10 : 2'b01), p, g, 2'b10, w};
  endfunction

  // vector: {read, phy, reg, wdata, phy response}
  localparam logic [42:0] VEC [6] = '{
    {1'b0, 5'h1F, 5'h00, 16'hA55A, 16'h0000},
    {1'b0, 5'h00, 5'h1F, 16'h0001, 16'h0000},
    {1'b1, 5'h15, 5'h0A, 16'h0000, 16'h8001},
    {1'b1, 5'h0A, 5'h15, 16'h0000, 16'h3C96},
    {1'b0, 5'h12, 5'h09, 16'h8000, 16'h0000},
    {1'b1, 5'h01, 5'h01, 16'h0000, 16'hFFFE}
  };

  initial begin
    #(200000 * 20);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] d;
    realtime t0, t1;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1: reset state
    check("R1 mdc/oe", {62'b0, mdc, mdio_oe}, 64'h0);
    rd(12'h7F0, d); check("R1 ctrl", 64'(d), 64'h0);
    rd(12'h7E4, d); check("R1 addr", 64'(d), 64'h0);
    rd(12'h7EC, d); check("R1 rdata", 64'(d), 64'h0);

    // R10: field widths on readback
    wr(12'h7E4, 32'hFFFF_FFFF); rd(12'h7E4, d); check("R10 addr", 64'(d), 64'h7FF);
    wr(12'h7E8, 32'hFFFF_FFFF); rd(12'h7E8, d); check("R10 wdata", 64'(d), 64'hFFFF);

    // R2: enable readback and gating
    wr(12'h7F0, 32'h8); rd(12'h7F0, d); check("R2 enable readback", 64'(d), 64'h8);
    pos = 0;
    wr(12'h7F0, 32'h1); rd(12'h7F0, d); check("R2 start without enable", 64'(d), 64'h0);
    repeat (4 * DH) @(negedge clk);
    check("R2 no mdc activity", 64'(pos), 64'h0);
    wr(12'h7F0, 32'h8);

    // table of frames: R4 R5 R6 R3
    for (int v = 0; v < 6; v++) begin
      logic r; logic [4:0] p, g; logic [15:0] w, rsp;
      logic [63:0] ef, em;
      {r, p, g, w, rsp} = VEC[v];
      resp = rsp;
      wr(12'h7E4, {21'b0, r, p, g});
      wr(12'h7E8, {16'hDEAD, w});
      kick(t0);
      rd(12'h7F0, d); check("R3 busy set", 64'(d), 64'h9);
      wait_idle(t1);
      check("R3 rising edges per frame", 64'(pos), 64'd64);
      ef = exp_frame(r, p, g, w);
      em = r ? {{46{1'b1}}, 18'b0} : {64{1'b1}};
      if (r) check("R5 output enable pattern", capoe, em);
      else   check("R4 output enable pattern", capoe, em);
      if (r) check("R5 read frame", cap & em, ef & em);
      else   check("R4 write frame", cap, ef);
      if (r) begin
        rd(12'h7EC, d); check("R6 read data", 64'(d), 64'(rsp));
      end
    end

    // R7: MDC period and idle level
    check("R7 mdc period ns", 64'(int'(t_rise_last - t_rise_prev)), 64'(2 * DH * 20));
    check("R7 mdc idle low", 64'(mdc), 64'h0);

    // R9: restart and clear writes while busy; R3 duration
    resp = 16'h5A5A;
    wr(12'h7E4, 32'h0000_0400 | (5'h07 << 5) | 5'h03);
    kick(t0);
    repeat (200) @(negedge clk);
    wr(12'h7F0, 32'h9);
    wr(12'h7F0, 32'h8);
    rd(12'h7F0, d); check("R9 busy kept after clear write", 64'(d), 64'h9);
    wait_idle(t1);
    n_chk++;
    if (((t1 - t0) / 20) < TXN_CYC || ((t1 - t0) / 20) > TXN_CYC + 3) begin
      n_bad++;
      $display("FAIL R3/R9 busy duration: actual %0d expected %0d..%0d",
               int'((t1 - t0) / 20), TXN_CYC, TXN_CYC + 3);
    end
    check("R9 no extra edges", 64'(pos), 64'd64);
    check("R9 frame intact", cap & {{46{1'b1}}, 18'b0},
          exp_frame(1'b1, 5'h07, 5'h03, 16'h0) & {{46{1'b1}}, 18'b0});
    rd(12'h7EC, d); check("R6 upper bits zero", 64'(d), 64'h5A5A);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule